// File: doc/BRIEF.md
# Asynchronous Serial Port with Break Generator

This block is a byte-wide asynchronous serial transmitter and receiver with a small register interface. Software writes a character into the data register to send it. It reads received characters from the same address, with a read strobe that marks the character as consumed. The frame is a start bit, eight data bits sent least significant first, an optional parity bit and one stop bit. The baud tick input gives the oversampling rate, and each bit lasts `OSR` ticks.

The transmitter can also send a synchronisation break. On a break request it holds the line at the active (low) level for a programmable 13 to 20 bit times, then sends one high bit time. The logic levels of the transmit and receive pins can each be inverted. The inversion bits and the break-length field are locked while the matching direction is enabled.

A status register holds a read-only transmitter-busy flag and three sticky receive error flags: parity, framing and overrun. Software clears an error flag by writing 0 to it. Disabling the block or its receiver also clears the error flags.

Top module: `uart_brk_core`

## Requirements
- R1: After reset, the configuration and status registers read 0x00, `txd_o` is high, `rx_ready` is low, and the break-length field selects 13 bit times.
- R2: A write to address 0 while power and transmit are enabled and the transmitter is idle sends one frame. The frame is a low start bit, data bits 0 to 7, and then, if configuration bit 0 is set, a parity bit (even parity, or odd when configuration bit 1 is set), then a high stop bit. Each bit lasts OSR baud ticks.
- R3: Status bit 7 (transmitter busy) is 1 from the first cycle of the start bit to the last cycle of the stop bit, and 0 afterwards. A data write while busy starts nothing.
- R4: A break request while the transmitter is idle drives the line low for 13+S bit times, where S is configuration bits 4:2. It then drives the line high for one bit time. The busy flag stays 1 for the whole sequence.
- R5: Configuration bit 5 inverts the level driven on `txd_o`. Configuration bit 6 inverts the level read from `rxd_i`.
- R6: Writes to configuration bits 4:2 and 5 are ignored while `pwr_en` and `tx_en` are both 1. Writes to configuration bit 6 are ignored while `pwr_en` and `rx_en` are both 1. Bits 1:0 can always be written.
- R7: A received frame loads its character into the buffer read at address 0 and raises `rx_ready`. A read of address 0 with `reg_rd` set lowers `rx_ready`.
- R8: A parity mismatch sets status bit 2. A stop bit sampled low sets status bit 1.
- R9: A frame that completes while `rx_ready` is still 1 sets status bit 0 (overrun), and the new character replaces the old one.
- R10: A status write clears each error flag whose mask bit is 1 and whose data bit is 0. Writing 1 to an error flag leaves it unchanged, and writes to status bit 7 are ignored.
- R11: Driving `pwr_en` or `tx_en` to 0 ends any transmission. Busy is 0 on the next cycle, and the line returns to its idle level.
- R12: Driving `pwr_en` or `rx_en` to 0 clears all three error flags.
- R13: When a flag's set event and a write of 0 to that flag fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_en | input | 1 | Block enable |
| tx_en | input | 1 | Transmitter enable |
| rx_en | input | 1 | Receiver enable |
| baud_tick | input | 1 | Oversampling tick, OSR per bit |
| brk_req | input | 1 | Break sequence request |
| reg_addr | input | 2 | Register address: 0 data, 1 configuration, 2 status |
| reg_wr | input | 1 | Register write strobe |
| reg_wmask | input | 8 | Per-bit write enable |
| reg_wdata | input | 8 | Write data |
| reg_rd | input | 1 | Read strobe; consumes the received character at address 0 |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| rx_ready | output | 1 | Unread received character present |
| txd_o | output | 1 | Serial transmit pin |
| rxd_i | input | 1 | Serial receive pin |

## Verification
The assertions assume that `rxd_i` changes only between bit windows that are several ticks long. They also assume that configuration writes happen only while the relevant direction is disabled or are meant to be rejected. The stimulus drives every receive bit for a full OSR cycles and holds the line idle between frames. It changes inversion and break length only after dropping the enables, apart from the deliberate lock checks. Random bytes and parity settings come from a fixed seed. Directed cases cover the shortest and longest breaks, inverted pins, a set colliding with a clear write, and the enable-drop clears.

// File: rtl/uart_brk_pkg.sv
// Shared constants and state types of the serial port with break generator.
// Assumes a fixed register map of three byte-wide registers.
package uart_brk_pkg;
    localparam logic [1:0] A_DATA = 2'd0;
    localparam logic [1:0] A_CFG  = 2'd1;
    localparam logic [1:0] A_STAT = 2'd2;

    localparam int BRK_SEL_W  = 3;
    localparam int CFG_PEN    = 0;
    localparam int CFG_PODD   = 1;
    localparam int CFG_BRK_LO = 2;
    localparam int CFG_TXINV  = CFG_BRK_LO + BRK_SEL_W;
    localparam int CFG_RXINV  = CFG_TXINV + 1;

    localparam int ST_OVR  = 0;
    localparam int ST_FRM  = 1;
    localparam int ST_PAR  = 2;
    localparam int ST_BUSY = 7;
    localparam int N_ERR   = 3;

    typedef enum logic [2:0] {
        TX_IDLE, TX_START, TX_DATA, TX_PAR, TX_STOP, TX_BRK, TX_BRKSTOP
    } tx_state_t;

    typedef enum logic [2:0] {
        RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP, RX_WAITHI
    } rx_state_t;
endpackage

// File: rtl/uart_brk_tx.sv
// Frame and break transmitter. Sends start, data (LSB first), optional
// parity and stop. A break is 13+sel low bits followed by one high bit.
// Assumes that tick marks one oversampling period and that a bit is OSR ticks.
module uart_brk_tx
    import uart_brk_pkg::*;
#(
    parameter int DW       = 8,
    parameter int OSR      = 16,
    parameter int BRK_BASE = 13
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic                 tick,
    input  logic                 start,
    input  logic                 brk,
    input  logic [DW-1:0]        data,
    input  logic                 par_en,
    input  logic                 par_odd,
    input  logic [BRK_SEL_W-1:0] brk_sel,
    output logic                 line,
    output logic                 busy
);
    localparam int TW      = $clog2(OSR);
    localparam int BRK_MAX = BRK_BASE + (1 << BRK_SEL_W) - 1;
    localparam int BW      = $clog2((BRK_MAX > DW ? BRK_MAX : DW) + 1);

    tx_state_t     st;
    logic [TW-1:0] tcnt;
    logic [BW-1:0] bcnt;
    logic [DW-1:0] shreg;
    logic          par_bit;
    logic          pen_q;
    logic          bit_end;

    assign bit_end = tick && (tcnt == TW'(OSR - 1));

    // State sequencing, bit timing and shifting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= TX_IDLE;
            tcnt    <= '0;
            bcnt    <= '0;
            shreg   <= '0;
            par_bit <= 1'b0;
            pen_q   <= 1'b0;
        end else if (!en) begin
            st   <= TX_IDLE;
            tcnt <= '0;
        end else if (st == TX_IDLE) begin
            tcnt <= '0;
            if (brk) begin
                st   <= TX_BRK;
                bcnt <= BW'(BRK_BASE) + BW'(brk_sel);
            end else if (start) begin
                st      <= TX_START;
                shreg   <= data;
                par_bit <= (^data) ^ par_odd;
                pen_q   <= par_en;
            end
        end else begin
            if (tick) tcnt <= bit_end ? '0 : tcnt + 1'b1;
            if (bit_end) begin
                case (st)
                    TX_START: begin
                        st   <= TX_DATA;
                        bcnt <= BW'(DW - 1);
                    end
                    TX_DATA: begin
                        shreg <= shreg >> 1;
                        if (bcnt == '0) st <= pen_q ? TX_PAR : TX_STOP;
                        else            bcnt <= bcnt - 1'b1;
                    end
                    TX_PAR:  st <= TX_STOP;
                    TX_BRK: begin
                        if (bcnt == BW'(1)) st <= TX_BRKSTOP;
                        else                bcnt <= bcnt - 1'b1;
                    end
                    default: st <= TX_IDLE;
                endcase
            end
        end
    end

    // Line level for the current state, before pin inversion
    always_comb begin
        case (st)
            TX_START: line = 1'b0;
            TX_DATA:  line = shreg[0];
            TX_PAR:   line = par_bit;
            TX_BRK:   line = 1'b0;
            default:  line = 1'b1;
        endcase
    end

    assign busy = (st != TX_IDLE);
endmodule

// File: rtl/uart_brk_rx.sv
// Frame receiver. Finds the start edge, samples each bit mid-window,
// and reports the character with its parity and stop-bit results as a
// one-cycle done pulse. Assumes a synchronised, polarity-corrected input.
module uart_brk_rx
    import uart_brk_pkg::*;
#(
    parameter int DW  = 8,
    parameter int OSR = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          tick,
    input  logic          rxd,
    input  logic          par_en,
    input  logic          par_odd,
    output logic          done,
    output logic [DW-1:0] rx_data,
    output logic          par_err,
    output logic          frm_err
);
    localparam int TW   = $clog2(OSR);
    localparam int BW   = $clog2(DW);
    localparam int HALF = OSR / 2;

    rx_state_t     st;
    logic [TW-1:0] tcnt;
    logic [BW-1:0] bcnt;
    logic [DW-1:0] shreg;
    logic          pen_q, odd_q, perr_q;
    logic          full;

    assign full = (tcnt == TW'(OSR - 1));

    // Start detection, mid-bit sampling and result capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= RX_IDLE;
            tcnt    <= '0;
            bcnt    <= '0;
            shreg   <= '0;
            pen_q   <= 1'b0;
            odd_q   <= 1'b0;
            perr_q  <= 1'b0;
            done    <= 1'b0;
            rx_data <= '0;
            par_err <= 1'b0;
            frm_err <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!en) begin
                st   <= RX_IDLE;
                tcnt <= '0;
            end else if (tick) begin
                case (st)
                    RX_IDLE: begin
                        tcnt <= '0;
                        if (!rxd) begin
                            st     <= RX_START;
                            pen_q  <= par_en;
                            odd_q  <= par_odd;
                            perr_q <= 1'b0;
                        end
                    end
                    RX_START: begin
                        if (tcnt == TW'(HALF - 1)) begin
                            tcnt <= '0;
                            bcnt <= '0;
                            st   <= rxd ? RX_IDLE : RX_DATA;
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                    RX_DATA: begin
                        tcnt <= full ? '0 : tcnt + 1'b1;
                        if (full) begin
                            shreg <= {rxd, shreg[DW-1:1]};
                            if (bcnt == BW'(DW - 1)) st <= pen_q ? RX_PAR : RX_STOP;
                            else                     bcnt <= bcnt + 1'b1;
                        end
                    end
                    RX_PAR: begin
                        tcnt <= full ? '0 : tcnt + 1'b1;
                        if (full) begin
                            perr_q <= rxd ^ (^shreg) ^ odd_q;
                            st     <= RX_STOP;
                        end
                    end
                    RX_STOP: begin
                        tcnt <= full ? '0 : tcnt + 1'b1;
                        if (full) begin
                            done    <= 1'b1;
                            rx_data <= shreg;
                            par_err <= perr_q;
                            frm_err <= !rxd;
                            st      <= rxd ? RX_IDLE : RX_WAITHI;
                        end
                    end
                    default: begin
                        tcnt <= '0;
                        if (rxd) st <= RX_IDLE;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/uart_brk_regs.sv
// Register file: configuration with per-direction write locks, sticky
// error flags (clear on written 0, hardware set wins), receive buffer and
// transmit launch. Assumes the bit-mask form of writes for every register
// except data, which takes any write as a whole byte.
module uart_brk_regs
    import uart_brk_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_on,
    input  logic             rx_on,
    input  logic [1:0]       addr,
    input  logic             wr,
    input  logic [DW-1:0]    wmask,
    input  logic [DW-1:0]    wdata,
    input  logic             rd,
    input  logic             tx_busy,
    input  logic             rx_done,
    input  logic [DW-1:0]    rx_data,
    input  logic             rx_perr,
    input  logic             rx_ferr,
    output logic [DW-1:0]    cfg,
    output logic [N_ERR-1:0] errs,
    output logic [DW-1:0]    rx_buf,
    output logic             rx_valid,
    output logic             tx_start
);
    logic [DW-1:0]    allow;
    logic [DW-1:0]    cmask;
    logic [N_ERR-1:0] clr, set;
    logic             wr_cfg, wr_st, rd_data;

    assign wr_cfg   = wr && (addr == A_CFG);
    assign wr_st    = wr && (addr == A_STAT);
    assign rd_data  = rd && (addr == A_DATA);
    assign tx_start = wr && (addr == A_DATA) && tx_on && !tx_busy;

    // Which configuration bits may be written now
    always_comb begin
        allow                           = '0;
        allow[CFG_PEN]                  = 1'b1;
        allow[CFG_PODD]                 = 1'b1;
        allow[CFG_BRK_LO +: BRK_SEL_W]  = {BRK_SEL_W{!tx_on}};
        allow[CFG_TXINV]                = !tx_on;
        allow[CFG_RXINV]                = !rx_on;
        cmask                           = wr_cfg ? (wmask & allow) : '0;
    end

    // Error-flag set and clear events
    always_comb begin
        set         = '0;
        set[ST_OVR] = rx_done && rx_valid && !rd_data;
        set[ST_FRM] = rx_done && rx_ferr;
        set[ST_PAR] = rx_done && rx_perr;
        clr         = wr_st ? (wmask[N_ERR-1:0] & ~wdata[N_ERR-1:0]) : '0;
    end

    // Configuration register update
    always_ff @(posedge clk) begin
        if (!rst_n) cfg <= '0;
        else        cfg <= (cfg & ~cmask) | (wdata & cmask);
    end

    // Sticky error flags, one per bit
    for (genvar i = 0; i < N_ERR; i++) begin : g_err
        always_ff @(posedge clk) begin
            if (!rst_n || !rx_on) errs[i] <= 1'b0;
            else if (set[i])      errs[i] <= 1'b1;
            else if (clr[i])      errs[i] <= 1'b0;
        end
    end

    // Receive buffer and its unread flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_buf   <= '0;
            rx_valid <= 1'b0;
        end else if (!rx_on) begin
            rx_valid <= 1'b0;
        end else if (rx_done) begin
            rx_buf   <= rx_data;
            rx_valid <= 1'b1;
        end else if (rd_data) begin
            rx_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/uart_brk_core.sv
// Top of the serial port with break generator. Applies pin inversion,
// synchronises the receive pin, and multiplexes register reads.
// Assumes that rxd_i is asynchronous and that baud_tick is a single-cycle strobe.
module uart_brk_core
    import uart_brk_pkg::*;
#(
    parameter int OSR         = 16,
    parameter int BRK_BASE    = 13,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_en,
    input  logic       tx_en,
    input  logic       rx_en,
    input  logic       baud_tick,
    input  logic       brk_req,
    input  logic [1:0] reg_addr,
    input  logic       reg_wr,
    input  logic [7:0] reg_wmask,
    input  logic [7:0] reg_wdata,
    input  logic       reg_rd,
    output logic [7:0] reg_rdata,
    output logic       rx_ready,
    output logic       txd_o,
    input  logic       rxd_i
);
    localparam int DW = 8;

    logic                 tx_on, rx_on;
    logic [DW-1:0]        cfg, rx_buf, rx_data;
    logic [N_ERR-1:0]     errs;
    logic                 tx_start, tx_busy, tx_line;
    logic                 rx_done, rx_perr, rx_ferr, rx_line;
    logic                 tx_inv, rx_inv;
    logic [BRK_SEL_W-1:0] brk_sel;

    assign tx_on   = pwr_en && tx_en;
    assign rx_on   = pwr_en && rx_en;
    assign tx_inv  = cfg[CFG_TXINV];
    assign rx_inv  = cfg[CFG_RXINV];
    assign brk_sel = cfg[CFG_BRK_LO +: BRK_SEL_W];
    assign txd_o   = tx_line ^ tx_inv;

    // Receive pin synchroniser, depth chosen by parameter
    if (SYNC_STAGES < 2) begin : g_sync1
        always_ff @(posedge clk) begin
            if (!rst_n) rx_line <= 1'b1;
            else        rx_line <= rxd_i ^ rx_inv;
        end
    end else begin : g_syncn
        logic [SYNC_STAGES-1:0] sq;
        always_ff @(posedge clk) begin
            if (!rst_n) sq <= '1;
            else        sq <= {sq[SYNC_STAGES-2:0], rxd_i ^ rx_inv};
        end
        assign rx_line = sq[SYNC_STAGES-1];
    end

    uart_brk_regs #(.DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .tx_on(tx_on), .rx_on(rx_on),
        .addr(reg_addr), .wr(reg_wr), .wmask(reg_wmask), .wdata(reg_wdata),
        .rd(reg_rd), .tx_busy(tx_busy), .rx_done(rx_done), .rx_data(rx_data),
        .rx_perr(rx_perr), .rx_ferr(rx_ferr), .cfg(cfg), .errs(errs),
        .rx_buf(rx_buf), .rx_valid(rx_ready), .tx_start(tx_start)
    );

    uart_brk_tx #(.DW(DW), .OSR(OSR), .BRK_BASE(BRK_BASE)) u_tx (
        .clk(clk), .rst_n(rst_n), .en(tx_on), .tick(baud_tick),
        .start(tx_start), .brk(brk_req), .data(reg_wdata),
        .par_en(cfg[CFG_PEN]), .par_odd(cfg[CFG_PODD]), .brk_sel(brk_sel),
        .line(tx_line), .busy(tx_busy)
    );

    uart_brk_rx #(.DW(DW), .OSR(OSR)) u_rx (
        .clk(clk), .rst_n(rst_n), .en(rx_on), .tick(baud_tick), .rxd(rx_line),
        .par_en(cfg[CFG_PEN]), .par_odd(cfg[CFG_PODD]), .done(rx_done),
        .rx_data(rx_data), .par_err(rx_perr), .frm_err(rx_ferr)
    );

    // Register read multiplexer
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_DATA: reg_rdata = rx_buf;
            A_CFG:  reg_rdata = cfg;
            A_STAT: begin
                reg_rdata[ST_BUSY] = tx_busy;
                reg_rdata[ST_PAR]  = errs[ST_PAR];
                reg_rdata[ST_FRM]  = errs[ST_FRM];
                reg_rdata[ST_OVR]  = errs[ST_OVR];
            end
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/uart_brk_chk.sv
// Property checker for uart_brk_core, attached by bind. It observes the
// enables, the register bus, the transmitter state and the error flags.
module uart_brk_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       pwr_en,
    input logic       tx_en,
    input logic       rx_en,
    input logic       reg_wr,
    input logic [1:0] reg_addr,
    input logic [7:0] reg_wmask,
    input logic [7:0] reg_wdata,
    input logic       tx_busy,
    input logic       txd_o,
    input logic       tx_inv,
    input logic       rx_inv,
    input logic [2:0] brk_sel,
    input logic [2:0] errs,
    input logic       rx_done,
    input logic       rx_ferr
);
    logic st_wr;
    assign st_wr = reg_wr && (reg_addr == 2'd2);

    a_r11_busy_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_en || !tx_en) |=> !tx_busy);

    a_r12_errs_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_en || !rx_en) |=> (errs == 3'b000));

    a_r6_tx_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_en && tx_en) |=> ($stable(brk_sel) && $stable(tx_inv)));

    a_r6_rx_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_en && rx_en) |=> $stable(rx_inv));

    a_r10_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (errs[0] && pwr_en && rx_en && !(st_wr && reg_wmask[0] && !reg_wdata[0])) |=> errs[0]);

    a_r10_frm_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (errs[1] && pwr_en && rx_en && !(st_wr && reg_wmask[1] && !reg_wdata[1])) |=> errs[1]);

    a_r10_par_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (errs[2] && pwr_en && rx_en && !(st_wr && reg_wmask[2] && !reg_wdata[2])) |=> errs[2]);

    a_r13_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && rx_ferr && pwr_en && rx_en) |=> errs[1]);

    a_r3_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> (txd_o == !tx_inv));
endmodule

bind uart_brk_core uart_brk_chk u_chk (
    .clk(clk), .rst_n(rst_n), .pwr_en(pwr_en), .tx_en(tx_en), .rx_en(rx_en),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wmask(reg_wmask),
    .reg_wdata(reg_wdata), .tx_busy(tx_busy), .txd_o(txd_o), .tx_inv(tx_inv),
    .rx_inv(rx_inv), .brk_sel(brk_sel), .errs(errs), .rx_done(rx_done),
    .rx_ferr(rx_ferr)
);

// File: tb/uart_brk_core_test.sv
`timescale 1ns/1ps
module uart_brk_core_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwr_en = 1'b0, tx_en = 1'b0, rx_en = 1'b0;
    logic       baud_tick = 1'b1, brk_req = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_wmask = 8'h00, reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       rx_ready, txd_o;
    logic       rxd_i = 1'b1;

    int n_chk = 0;
    int n_fail = 0;

    uart_brk_core uut (
        .clk(clk), .rst_n(rst_n), .pwr_en(pwr_en), .tx_en(tx_en), .rx_en(rx_en),
        .baud_tick(baud_tick), .brk_req(brk_req), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_wmask(reg_wmask), .reg_wdata(reg_wdata),
        .reg_rd(reg_rd), .reg_rdata(reg_rdata), .rx_ready(rx_ready),
        .txd_o(txd_o), .rxd_i(rxd_i)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wreg(input logic [1:0] a, input logic [7:0] m, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wmask = m; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rreg(input logic [1:0] a, input bit consume, output logic [7:0] v);
        @(negedge clk);
        reg_addr = a; reg_rd = consume;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    function automatic logic [7:0] cfg_val(input bit pen, input bit podd, input int sel,
                                           input bit tinv, input bit rinv);
        return {1'b0, rinv, tinv, 3'(sel), podd, pen};
    endfunction

    function automatic logic [10:0] exp_frame(input logic [7:0] d, input bit pen, input bit podd);
        logic [10:0] f;
        f = '0;
        f[8:1] = d;
        if (pen) begin
            f[9] = (^d) ^ podd;
            f[10] = 1'b1;
        end else begin
            f[9] = 1'b1;
        end
        return f;
    endfunction

    // Write the configuration with both directions disabled, then restore them.
    task automatic set_cfg(input logic [7:0] c);
        logic t, r;
        t = tx_en; r = rx_en;
        @(negedge clk); tx_en = 1'b0; rx_en = 1'b0;
        wreg(2'd1, 8'hFF, c);
        @(negedge clk); tx_en = t; rx_en = r;
    endtask

    // Capture one transmitted frame; called at the negedge after the launch write.
    task automatic tx_capture(input bit pen, input bit inv, output logic [10:0] got,
                              output bit busy_ok, output bit busy_late, output bit busy_after);
        int nb;
        int guard;
        nb = pen ? 11 : 10;
        guard = 0;
        got = '0;
        busy_ok = 1'b1;
        reg_addr = 2'd2;
        while (txd_o !== inv && guard < 200) begin @(negedge clk); guard++; end
        repeat (8) @(negedge clk);
        for (int k = 0; k < nb; k++) begin
            got[k] = txd_o ^ inv;
            if (!reg_rdata[7]) busy_ok = 1'b0;
            if (k != nb - 1) repeat (16) @(negedge clk);
        end
        repeat (7) @(negedge clk);
        busy_late = reg_rdata[7];
        @(negedge clk);
        busy_after = reg_rdata[7];
    endtask

    task automatic tx_frame_test(input logic [7:0] d, input bit pen, input bit podd, input bit inv);
        logic [10:0] got;
        bit bok, blate, bafter;
        set_cfg(cfg_val(pen, podd, 0, inv, 1'b0));
        wreg(2'd0, 8'hFF, d);
        tx_capture(pen, inv, got, bok, blate, bafter);
        chk(got == exp_frame(d, pen, podd), inv ? "R5 tx inverted frame" : "R2 tx frame bits",
            int'(got), int'(exp_frame(d, pen, podd)));
        chk(bok && blate, "R3 busy during frame", int'({bok, blate}), 3);
        chk(!bafter, "R3 busy cleared after stop", int'(bafter), 0);
    endtask

    task automatic brk_test(input int sel, input bit inv);
        int lo, hi;
        lo = 0; hi = 0;
        set_cfg(cfg_val(1'b0, 1'b0, sel, inv, 1'b0));
        @(negedge clk); reg_addr = 2'd2; brk_req = 1'b1;
        @(negedge clk); brk_req = 1'b0;
        while (txd_o == inv && reg_rdata[7] && lo < 2000) begin lo++; @(negedge clk); end
        while (txd_o == !inv && reg_rdata[7] && hi < 100) begin hi++; @(negedge clk); end
        chk(lo == 16 * (13 + sel), "R4 break low length", lo, 16 * (13 + sel));
        chk(hi == 16, "R4 break trailing high bit", hi, 16);
        chk(!reg_rdata[7], "R4 busy ends after break", int'(reg_rdata[7]), 0);
    endtask

    // Drive one frame into rxd_i, then idle for two bit times.
    task automatic rx_drive(input logic [7:0] d, input bit pen, input bit podd,
                            input bit bad_par, input bit bad_stop, input bit inv);
        logic [10:0] f;
        int nb;
        f = exp_frame(d, pen, podd);
        nb = pen ? 11 : 10;
        if (pen && bad_par) f[9] = ~f[9];
        if (bad_stop) f[nb - 1] = 1'b0;
        for (int k = 0; k < nb; k++) begin
            @(negedge clk); rxd_i = f[k] ^ inv;
            repeat (15) @(negedge clk);
        end
        @(negedge clk); rxd_i = 1'b1 ^ inv;
        repeat (31) @(negedge clk);
    endtask

    task automatic rx_good_test(input logic [7:0] d, input bit pen, input bit podd, input bit inv);
        logic [7:0] v, s;
        rx_drive(d, pen, podd, 1'b0, 1'b0, inv);
        chk(rx_ready == 1'b1, "R7 rx_ready after frame", int'(rx_ready), 1);
        rreg(2'd2, 1'b0, s);
        chk(s[2:0] == 3'b000, "R8 no error on clean frame", int'(s), 0);
        rreg(2'd0, 1'b1, v);
        chk(v == d, inv ? "R5 rx inverted data" : "R7 rx data", int'(v), int'(d));
        @(negedge clk);
        chk(rx_ready == 1'b0, "R7 rx_ready cleared by read", int'(rx_ready), 0);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] v, s;
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'h1A2B);

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        rreg(2'd1, 1'b0, v);
        chk(v == 8'h00, "R1 cfg reset (13-bit break)", int'(v), 0);
        rreg(2'd2, 1'b0, v);
        chk(v == 8'h00, "R1 status reset", int'(v), 0);
        chk(txd_o == 1'b1 && rx_ready == 1'b0, "R1 pins at reset", int'({txd_o, rx_ready}), 2);

        // R6 configuration locks
        @(negedge clk); pwr_en = 1'b1; tx_en = 1'b1; rx_en = 1'b1;
        wreg(2'd1, 8'hFF, 8'h7F);
        rreg(2'd1, 1'b0, v);
        chk(v == 8'h03, "R6 locked while both enabled", int'(v), 8'h03);
        @(negedge clk); tx_en = 1'b0;
        wreg(2'd1, 8'hFF, 8'h7F);
        rreg(2'd1, 1'b0, v);
        chk(v == 8'h3F, "R6 tx fields open, rx bit locked", int'(v), 8'h3F);
        @(negedge clk); rx_en = 1'b0;
        wreg(2'd1, 8'hFF, 8'h7F);
        rreg(2'd1, 1'b0, v);
        chk(v == 8'h7F, "R6 rx bit open", int'(v), 8'h7F);
        wreg(2'd1, 8'hFF, 8'h00);
        @(negedge clk); tx_en = 1'b1; rx_en = 1'b1;

        // R2 R3 directed and random transmit frames
        tx_frame_test(8'hA5, 1'b0, 1'b0, 1'b0);
        tx_frame_test(8'h00, 1'b1, 1'b1, 1'b0);
        for (int i = 0; i < 5; i++)
            tx_frame_test(8'($urandom), 1'($urandom), 1'($urandom), 1'b0);
        tx_frame_test(8'h3C, 1'b1, 1'b0, 1'b1); // R5

        // R3 data write while busy starts nothing; R10 busy bit ignores writes
        set_cfg(8'h00);
        wreg(2'd0, 8'hFF, 8'h55);
        wreg(2'd0, 8'hFF, 8'h0F);
        wreg(2'd2, 8'h80, 8'h00);
        rreg(2'd2, 1'b0, s);
        chk(s[7] == 1'b1, "R10 busy bit not writable", int'(s[7]), 1);
        repeat (200) @(negedge clk);
        begin
            int lows;
            lows = 0;
            for (int k = 0; k < 60; k++) begin
                @(negedge clk);
                if (txd_o == 1'b0) lows++;
            end
            chk(lows == 0, "R3 write during busy ignored", lows, 0);
        end

        // R4 break lengths
        brk_test(0, 1'b0);
        brk_test(7, 1'b0);
        brk_test(int'($urandom % 8), 1'b1);

        // R11 transmit enable drop aborts
        set_cfg(8'h00);
        wreg(2'd0, 8'hFF, 8'h00);
        repeat (30) @(negedge clk);
        tx_en = 1'b0;
        @(negedge clk); reg_addr = 2'd2;
        #1;
        chk(!reg_rdata[7] && txd_o, "R11 tx_en drop ends frame", int'({reg_rdata[7], txd_o}), 1);
        @(negedge clk); tx_en = 1'b1;
        brk_req = 1'b1; @(negedge clk); brk_req = 1'b0;
        repeat (20) @(negedge clk);
        pwr_en = 1'b0;
        @(negedge clk); #1;
        chk(!reg_rdata[7] && txd_o, "R11 pwr drop ends break", int'({reg_rdata[7], txd_o}), 1);
        @(negedge clk); pwr_en = 1'b1;

        // R7 receive clean frames
        set_cfg(8'h00);
        rx_good_test(8'h96, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 5; i++) begin
            bit pen, podd;
            pen = 1'($urandom); podd = 1'($urandom);
            wreg(2'd1, 8'h03, {6'b0, podd, pen});
            rx_good_test(8'($urandom), pen, podd, 1'b0);
        end
        set_cfg(cfg_val(1'b1, 1'b0, 0, 1'b0, 1'b1));
        rx_good_test(8'hC3, 1'b1, 1'b0, 1'b1); // R5
        set_cfg(cfg_val(1'b1, 1'b0, 0, 1'b0, 1'b0));

        // R8 parity error, R10 write semantics
        rx_drive(8'h5A, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
        rreg(2'd0, 1'b1, v);
        rreg(2'd2, 1'b0, s);
        chk(s[2:0] == 3'b100, "R8 parity error flag", int'(s[2:0]), 4);
        wreg(2'd2, 8'hFF, 8'hFF);
        rreg(2'd2, 1'b0, s);
        chk(s[2:0] == 3'b100, "R10 write 1 retains", int'(s[2:0]), 4);
        wreg(2'd2, 8'h02, 8'h00);
        rreg(2'd2, 1'b0, s);
        chk(s[2:0] == 3'b100, "R10 unmasked flag kept", int'(s[2:0]), 4);
        wreg(2'd2, 8'h04, 8'h00);
        rreg(2'd2, 1'b0, s);
        chk(s[2:0] == 3'b000, "R10 write 0 clears", int'(s[2:0]), 0);

        // R8 framing error
        rx_drive(8'h11, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
        rreg(2'd0, 1'b1, v);
        rreg(2'd2, 1'b0, s);
        chk(s[2:0] == 3'b010, "R8 framing error flag", int'(s[2:0]), 2);
        wreg(2'd2, 8'h07, 8'h00);

        // R9 overrun
        rx_drive(8'h21, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        rx_drive(8'h42, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        rreg(2'd2, 1'b0, s);
        chk(s[2:0] == 3'b001, "R9 overrun flag", int'(s[2:0]), 1);
        rreg(2'd0, 1'b1, v);
        chk(v == 8'h42, "R9 newest character kept", int'(v), 8'h42);
        wreg(2'd2, 8'h07, 8'h00);

        // R13 set wins over a clearing write in the same cycle
        fork
            rx_drive(8'h77, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
            begin
                int g;
                g = 0;
                @(negedge clk);
                reg_addr = 2'd2; reg_wmask = 8'h02; reg_wdata = 8'h00; reg_wr = 1'b1;
                while (!rx_ready && g < 400) begin @(negedge clk); g++; end
                reg_wr = 1'b0;
            end
        join
        rreg(2'd2, 1'b0, s);
        chk(s[1] == 1'b1, "R13 set beats write of 0", int'(s[1]), 1);

        // R12 receiver enable drop clears errors
        @(negedge clk); rx_en = 1'b0;
        @(negedge clk); rx_en = 1'b1;
        rreg(2'd2, 1'b0, s);
        chk(s[2:0] == 3'b000, "R12 rx_en drop clears", int'(s[2:0]), 0);
        rx_drive(8'h5A, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
        @(negedge clk); pwr_en = 1'b0;
        @(negedge clk); pwr_en = 1'b1;
        rreg(2'd2, 1'b0, s);
        chk(s[2:0] == 3'b000, "R12 pwr drop clears", int'(s[2:0]), 0);

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule